// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Window

This block lets a host read up to four serial flash chips as if they were ordinary read-only memory. The host address space is split into one fixed-size window per chip: the upper address bits pick the chip and the lower bits give the byte offset inside that chip. Each accepted host read becomes one serial read frame on a single-bit SPI bus. The frame carries a read command byte and a 24-bit offset, then clocks in one to four data bytes, which are packed into a 32-bit word with the first byte in the lowest lane.

A host stall input lets software hold off host reads while it drives its own transfers on the same flash bus. A host read that arrives during the stall waits with ready low and is served once the stall drops. A frame that has already started always runs to the end. A read whose last byte falls at or beyond the configured window size, or which would run past the end of one chip's window, is refused. It completes with an error flag and all-ones data, and no chip is selected.

Top module: `flash_read_window`

## Requirements
- R1: Address bits [25:24] select the chip. Only that chip's active-low select is driven low during its frame, and at most one select is ever low.
- R2: A frame shifts out MSB first the byte 0x03 and then the 24-bit offset (address bits [23:0]) on `spi_mosi_o`. The clock idles low, and MOSI never changes on a rising clock edge.
- R3: `rd_size_i` encodes the byte count N minus one (0 means 1 byte, 3 means 4 bytes). A frame has exactly 32 + 8·N rising clock edges.
- R4: The first byte received lands in `rd_data_o[7:0]`, the next in [15:8], and so on. Lanes above N read as zero. Each byte arrives MSB first and is sampled on the rising clock edge.
- R5: A served read completes with `rd_ready_o` high for exactly one cycle and `rd_err_o` low.
- R6: A read with start address plus N−1 at or beyond `WINDOW_BYTES` completes with `rd_err_o` high, `rd_data_o` all ones and no chip select asserted.
- R7: A read whose offset plus N−1 exceeds 0xFFFFFF, crossing into the next chip's window, is refused in the same way as R6.
- R8: While `host_stall_i` is high, no new frame starts and `rd_ready_o` stays low. The request is served with correct data after the stall falls.
- R9: Raising `host_stall_i` during a running frame does not abort that frame, and its data is returned correctly.
- R10: After reset all chip selects are high, the serial clock and MOSI are low, and `rd_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_stall_i | input | 1 | Holds off new host reads while high |
| rd_req_i | input | 1 | Host read request, held until ready |
| rd_addr_i | input | 26 | Host byte address: chip index above the 24-bit offset |
| rd_size_i | input | 2 | Byte count minus one |
| rd_ready_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 32 | Read data, first byte in the lowest lane |
| rd_err_o | output | 1 | Read refused (out of window or crossing a chip) |
| spi_sclk_o | output | 1 | Serial clock, idle low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_cs_n_o | output | 4 | Active-low chip selects, one per chip |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The bench keeps four chips and 24-bit offsets but sets `WINDOW_BYTES` to 40 MiB. This gives chip 0 and chip 1 full windows, chip 2 a window cut off halfway, and chip 3 no window at all. With that value, both the window-limit refusal and a read that ends exactly on the limit can be reached with short directed addresses. Random reads are weighted toward the last bytes of a chip, where the boundary check matters.

// File: rtl/flash_win_pkg.sv
package flash_win_pkg;

   // Serial command byte for a plain read and the width of the flash offset field
   localparam logic [7:0]  FW_RD_OPCODE = 8'h03;
   localparam int unsigned FW_FLASH_AW  = 24;
   localparam int unsigned FW_HDR_BITS  = 8 + FW_FLASH_AW;

   typedef enum logic [1:0] {
      FW_IDLE = 2'd0,
      FW_BUSY = 2'd1,
      FW_RESP = 2'd2
   } fw_state_e;

endpackage

// File: rtl/fw_addr_decode.sv
module fw_addr_decode #(
   parameter int unsigned NUM_CS       = 4,
   parameter int unsigned OFF_BITS     = 24,
   parameter int unsigned SIZE_W       = 2,
   parameter int unsigned WINDOW_BYTES = 32'h0400_0000,
   parameter int unsigned CS_W         = 2,
   parameter int unsigned ADDR_W       = 26
) (
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [SIZE_W-1:0]   size_m1_i,
   output logic [CS_W-1:0]     cs_idx_o,
   output logic [OFF_BITS-1:0] offset_o,
   output logic                accept_o
);

   localparam logic [ADDR_W:0] WIN_LIM = (ADDR_W+1)'(WINDOW_BYTES);

   logic [ADDR_W:0]   last_addr;
   logic [OFF_BITS:0] last_off;
   logic              beyond_win;
   logic              crosses_chip;

   generate
      if (NUM_CS > 1) begin : g_multi_cs
         assign cs_idx_o = addr_i[ADDR_W-1 -: CS_W];
      end else begin : g_single_cs
         assign cs_idx_o = '0;
      end
   endgenerate

   assign offset_o     = addr_i[OFF_BITS-1:0];
   assign last_addr    = {1'b0, addr_i} + (ADDR_W+1)'(size_m1_i);
   assign last_off     = {1'b0, addr_i[OFF_BITS-1:0]} + (OFF_BITS+1)'(size_m1_i);
   assign beyond_win   = (last_addr >= WIN_LIM);
   assign crosses_chip = last_off[OFF_BITS];
   assign accept_o     = !beyond_win && !crosses_chip;

endmodule

// File: rtl/fw_spi_engine.sv
module fw_spi_engine #(
   parameter int unsigned NUM_CS    = 4,
   parameter int unsigned CS_W      = 2,
   parameter int unsigned HDR_BITS  = 32,
   parameter int unsigned MAX_BYTES = 4,
   parameter int unsigned SIZE_W    = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [CS_W-1:0]        cs_idx_i,
   input  logic [HDR_BITS-1:0]    hdr_i,
   input  logic [SIZE_W-1:0]      size_m1_i,
   input  logic                   miso_i,
   output logic                   done_o,
   output logic [8*MAX_BYTES-1:0] rx_o,
   output logic                   sclk_o,
   output logic                   mosi_o,
   output logic [NUM_CS-1:0]      cs_n_o
);

   localparam int unsigned RX_BITS = 8 * MAX_BYTES;
   localparam int unsigned TOT_MAX = HDR_BITS + RX_BITS;
   localparam int unsigned CNT_W   = $clog2(TOT_MAX + 1);

   logic                busy_q;
   logic                sclk_q;
   logic                done_q;
   logic [CNT_W-1:0]    left_q;
   logic [CNT_W-1:0]    rxlen_q;
   logic [HDR_BITS-1:0] hdr_q;
   logic [RX_BITS-1:0]  rx_q;
   logic [NUM_CS-1:0]   sel_q;
   logic [CNT_W-1:0]    rx_need;

   assign rx_need = (CNT_W'(size_m1_i) + CNT_W'(1)) << 3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         sclk_q  <= 1'b0;
         done_q  <= 1'b0;
         left_q  <= '0;
         rxlen_q <= '0;
         hdr_q   <= '0;
         rx_q    <= '0;
         sel_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q  <= 1'b1;
               sclk_q  <= 1'b0;
               hdr_q   <= hdr_i;
               rx_q    <= '0;
               rxlen_q <= rx_need;
               left_q  <= CNT_W'(HDR_BITS) + rx_need;
               for (int i = 0; i < NUM_CS; i++) begin
                  sel_q[i] <= (cs_idx_i == CS_W'(i));
               end
            end
         end else if (!sclk_q) begin
            sclk_q <= 1'b1;
         end else begin
            sclk_q <= 1'b0;
            left_q <= left_q - CNT_W'(1);
            hdr_q  <= {hdr_q[HDR_BITS-2:0], 1'b0};
            if (left_q <= rxlen_q) begin
               rx_q <= {rx_q[RX_BITS-2:0], miso_i};
            end
            if (left_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   generate
      for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
         assign cs_n_o[c] = ~(busy_q & sel_q[c]);
      end
   endgenerate

   assign sclk_o = sclk_q;
   assign mosi_o = busy_q & hdr_q[HDR_BITS-1];
   assign done_o = done_q;
   assign rx_o   = rx_q;

   // Independent count of rising serial clock edges per frame
   logic [CNT_W-1:0] chk_rises_q;
   logic [CNT_W-1:0] chk_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_rises_q <= '0;
         chk_len_q   <= '0;
      end else if (start_i && !busy_q) begin
         chk_rises_q <= '0;
         chk_len_q   <= CNT_W'(HDR_BITS) + ((CNT_W'(size_m1_i) + CNT_W'(1)) << 3);
      end else if (busy_q && !sclk_q) begin
         chk_rises_q <= chk_rises_q + CNT_W'(1);
      end
   end

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n_o)); // R1
   AST_MOSI_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk_o) |-> $stable(mosi_o)); // R2
   AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) (&cs_n_o) |-> !sclk_o); // R2
   AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (chk_rises_q == chk_len_q)); // R3

endmodule

// File: rtl/fw_le_pack.sv
module fw_le_pack #(
   parameter int unsigned MAX_BYTES = 4,
   parameter int unsigned SIZE_W    = 2
) (
   input  logic [8*MAX_BYTES-1:0] raw_i,
   input  logic [SIZE_W-1:0]      size_m1_i,
   output logic [8*MAX_BYTES-1:0] word_o
);

   // raw_i holds the received stream right-aligned, first byte highest
   generate
      for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
         logic [SIZE_W-1:0] src;
         always_comb begin
            src = size_m1_i - SIZE_W'(k);
            if (SIZE_W'(k) <= size_m1_i) begin
               word_o[k*8 +: 8] = raw_i[{src, 3'b000} +: 8];
            end else begin
               word_o[k*8 +: 8] = 8'h00;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/flash_read_window.sv
module flash_read_window
   import flash_win_pkg::*;
#(
   parameter int unsigned NUM_CS       = 4,
   parameter int unsigned OFF_BITS     = 24,
   parameter int unsigned MAX_BYTES    = 4,
   parameter int unsigned WINDOW_BYTES = 32'h0400_0000,
   localparam int unsigned CS_W        = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int unsigned ADDR_W      = OFF_BITS + ((NUM_CS > 1) ? $clog2(NUM_CS) : 0),
   localparam int unsigned SIZE_W      = $clog2(MAX_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   host_stall_i,
   input  logic                   rd_req_i,
   input  logic [ADDR_W-1:0]      rd_addr_i,
   input  logic [SIZE_W-1:0]      rd_size_i,
   output logic                   rd_ready_o,
   output logic [8*MAX_BYTES-1:0] rd_data_o,
   output logic                   rd_err_o,
   output logic                   spi_sclk_o,
   output logic                   spi_mosi_o,
   output logic [NUM_CS-1:0]      spi_cs_n_o,
   input  logic                   spi_miso_i
);

   generate
      if (NUM_CS < 1) begin : g_bad_cs
         $error("NUM_CS must be at least 1");
      end
      if (OFF_BITS < 1 || OFF_BITS > FW_FLASH_AW) begin : g_bad_off
         $error("OFF_BITS must lie in 1..24");
      end
      if (MAX_BYTES < 2 || (MAX_BYTES & (MAX_BYTES - 1)) != 0) begin : g_bad_bytes
         $error("MAX_BYTES must be a power of two, at least 2");
      end
      if (ADDR_W > 31) begin : g_bad_aw
         $error("host address too wide");
      end
      if (WINDOW_BYTES == 0 || longint'(WINDOW_BYTES) > (longint'(NUM_CS) << OFF_BITS)) begin : g_bad_win
         $error("WINDOW_BYTES must lie in 1..NUM_CS chip windows");
      end
   endgenerate

   fw_state_e                state_q;
   logic [SIZE_W-1:0]        size_q;
   logic [8*MAX_BYTES-1:0]   data_q;
   logic                     err_q;

   logic [CS_W-1:0]          dec_cs;
   logic [OFF_BITS-1:0]      dec_off;
   logic                     dec_ok;
   logic                     take;
   logic                     eng_start;
   logic                     eng_done;
   logic [8*MAX_BYTES-1:0]   eng_rx;
   logic [8*MAX_BYTES-1:0]   packed_word;
   logic [FW_HDR_BITS-1:0]   hdr;

   fw_addr_decode #(
      .NUM_CS       (NUM_CS),
      .OFF_BITS     (OFF_BITS),
      .SIZE_W       (SIZE_W),
      .WINDOW_BYTES (WINDOW_BYTES),
      .CS_W         (CS_W),
      .ADDR_W       (ADDR_W)
   ) u_decode (
      .addr_i    (rd_addr_i),
      .size_m1_i (rd_size_i),
      .cs_idx_o  (dec_cs),
      .offset_o  (dec_off),
      .accept_o  (dec_ok)
   );

   assign take      = (state_q == FW_IDLE) && rd_req_i && !host_stall_i;
   assign eng_start = take && dec_ok;
   assign hdr       = {FW_RD_OPCODE, FW_FLASH_AW'(dec_off)};

   fw_spi_engine #(
      .NUM_CS    (NUM_CS),
      .CS_W      (CS_W),
      .HDR_BITS  (FW_HDR_BITS),
      .MAX_BYTES (MAX_BYTES),
      .SIZE_W    (SIZE_W)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (eng_start),
      .cs_idx_i  (dec_cs),
      .hdr_i     (hdr),
      .size_m1_i (rd_size_i),
      .miso_i    (spi_miso_i),
      .done_o    (eng_done),
      .rx_o      (eng_rx),
      .sclk_o    (spi_sclk_o),
      .mosi_o    (spi_mosi_o),
      .cs_n_o    (spi_cs_n_o)
   );

   fw_le_pack #(
      .MAX_BYTES (MAX_BYTES),
      .SIZE_W    (SIZE_W)
   ) u_pack (
      .raw_i     (eng_rx),
      .size_m1_i (size_q),
      .word_o    (packed_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FW_IDLE;
         size_q  <= '0;
         data_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            FW_IDLE: begin
               if (take) begin
                  size_q <= rd_size_i;
                  if (dec_ok) begin
                     state_q <= FW_BUSY;
                  end else begin
                     data_q  <= '1;
                     err_q   <= 1'b1;
                     state_q <= FW_RESP;
                  end
               end
            end
            FW_BUSY: begin
               if (eng_done) begin
                  data_q  <= packed_word;
                  err_q   <= 1'b0;
                  state_q <= FW_RESP;
               end
            end
            FW_RESP: begin
               state_q <= FW_IDLE;
            end
            default: state_q <= FW_IDLE;
         endcase
      end
   end

   assign rd_ready_o = (state_q == FW_RESP);
   assign rd_data_o  = data_q;
   assign rd_err_o   = err_q;

   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_ready_o |=> !rd_ready_o); // R5
   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (rd_ready_o && rd_err_o) |-> (&spi_cs_n_o)); // R6
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((state_q == FW_IDLE) && host_stall_i) |=> (&spi_cs_n_o)); // R8
   AST_BUSY_SELECTS: assert property (@(posedge clk) disable iff (!rst_n) (state_q == FW_BUSY && !eng_done) |-> !(&spi_cs_n_o)); // R9

endmodule

// File: tb/flash_read_window_bench.sv
`timescale 1ns/1ps
module flash_read_window_bench;

   localparam int unsigned WIN = 32'h0280_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_stall = 1'b0;
   logic        rd_req = 1'b0;
   logic [25:0] rd_addr = '0;
   logic [1:0]  rd_size = '0;
   logic        rd_ready;
   logic [31:0] rd_data;
   logic        rd_err;
   logic        sclk;
   logic        mosi;
   logic [3:0]  cs_n;
   logic        miso;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   flash_read_window #(.WINDOW_BYTES(WIN)) u_flash_read_window (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_stall_i (host_stall),
      .rd_req_i     (rd_req),
      .rd_addr_i    (rd_addr),
      .rd_size_i    (rd_size),
      .rd_ready_o   (rd_ready),
      .rd_data_o    (rd_data),
      .rd_err_o     (rd_err),
      .spi_sclk_o   (sclk),
      .spi_mosi_o   (mosi),
      .spi_cs_n_o   (cs_n),
      .spi_miso_i   (miso)
   );

   // Contents of the modelled flash chips
   function automatic logic [7:0] fbyte(int chip, logic [23:0] off);
      return 8'(chip * 8'h5B) ^ off[7:0] ^ 8'(off[15:8] * 3) ^ 8'(off[23:16] * 7) ^ 8'hA6;
   endfunction

   // Flash slave model
   logic        cs_idle;
   int          s_bits = 0;
   logic [31:0] s_hdr = '0;
   int          s_sel = 0;
   int          frames = 0;
   int          last_bits = 0;
   logic [31:0] last_hdr = '0;
   int          last_sel = -1;

   assign cs_idle = &cs_n;

   always @(posedge sclk or posedge cs_idle) begin
      if (cs_idle) begin
         if (s_bits != 0) begin
            frames    = frames + 1;
            last_bits = s_bits;
            last_hdr  = s_hdr;
            last_sel  = s_sel;
         end
         s_bits = 0;
      end else begin
         if (s_bits == 0) begin
            for (int i = 0; i < 4; i++) if (!cs_n[i]) s_sel = i;
         end
         if (s_bits < 32) s_hdr = {s_hdr[30:0], mosi};
         s_bits = s_bits + 1;
      end
   end

   function automatic logic slave_bit(int chip, logic [31:0] h, int b);
      int j;
      logic [7:0] v;
      if (b <= 32) return 1'b0;
      j = b - 33;
      v = fbyte(chip, h[23:0] + 24'(j / 8));
      return v[7 - (j % 8)];
   endfunction

   assign miso = slave_bit(s_sel, s_hdr, s_bits);

   // Expected-value models
   function automatic logic exp_reject(logic [25:0] a, int n);
      return ((longint'(a) + n - 1) >= longint'(WIN)) || ((int'(a[23:0]) + n - 1) > 32'hFF_FFFF);
   endfunction

   function automatic logic [31:0] exp_word(logic [25:0] a, int n);
      logic [31:0] w = '0;
      for (int k = 0; k < n; k++) w[k*8 +: 8] = fbyte(int'(a[25:24]), a[23:0] + 24'(k));
      return w;
   endfunction

   task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic wait_ready();
      do @(negedge clk); while (!rd_ready);
      rd_req = 1'b0;
   endtask

   task automatic check_result(logic [25:0] a, int n, int f0);
      if (exp_reject(a, n)) begin
         chk(((a[23:0] + 24'(n - 1)) < a[23:0]) ? "R7 err flag" : "R6 err flag", rd_err, 1'b1);
         chk("R6 all-ones data", rd_data, 32'hFFFF_FFFF);
         chk("R6 no frame", frames, f0);
      end else begin
         chk("R5 err low", rd_err, 1'b0);
         chk("R4 data", rd_data, exp_word(a, n));
         chk("R1 chip", last_sel, int'(a[25:24]));
         chk("R2 header", last_hdr, {8'h03, a[23:0]});
         chk("R3 clocks", last_bits, 32 + 8 * n);
         chk("R1 one frame", frames, f0 + 1);
      end
   endtask

   task automatic host_read(logic [25:0] a, int n);
      int f0;
      f0 = frames;
      @(negedge clk);
      rd_req  = 1'b1;
      rd_addr = a;
      rd_size = 2'(n - 1);
      wait_ready();
      check_result(a, n, f0);
      @(negedge clk);
      chk("R5 single pulse", rd_ready, 1'b0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R5 watchdog: actual=no completion expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : stim
      logic [25:0] a;
      int n;
      int f0;
      logic seen;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk("R10 cs idle in reset", cs_n, 4'hF);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 cs idle", cs_n, 4'hF);
      chk("R10 sclk low", sclk, 1'b0);
      chk("R10 mosi low", mosi, 1'b0);
      chk("R10 ready low", rd_ready, 1'b0);

      // Directed corner cases
      host_read(26'h000_0000, 4);
      host_read(26'h1AB_CDEF, 4);
      host_read(26'h0FF_FFFE, 2);
      host_read(26'h0FF_FFFE, 3);   // R7 crosses chip boundary
      host_read(26'h27F_FFFF, 1);   // last mapped byte
      host_read(26'h27F_FFFE, 4);   // R6 beyond window
      host_read(26'h300_0010, 1);   // R6 chip without window
      host_read(26'h212_3456, 3);

      // R8: stall holds a request
      f0 = frames;
      host_stall = 1'b1;
      @(negedge clk);
      rd_req = 1'b1; rd_addr = 26'h055_AA01; rd_size = 2'd3;
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (rd_ready || !cs_idle) seen = 1'b1;
      end
      chk("R8 held while stalled", seen, 1'b0);
      chk("R8 no frame while stalled", frames, f0);
      host_stall = 1'b0;
      wait_ready();
      check_result(26'h055_AA01, 4, f0);

      // R9: stall raised mid-frame does not abort it
      f0 = frames;
      @(negedge clk);
      rd_req = 1'b1; rd_addr = 26'h1C0_0F0F; rd_size = 2'd1;
      repeat (6) @(negedge clk);
      chk("R9 frame running", cs_idle, 1'b0);
      host_stall = 1'b1;
      wait_ready();
      host_stall = 1'b0;
      check_result(26'h1C0_0F0F, 2, f0);

      // Constrained random reads
      for (int it = 0; it < 160; it++) begin
         a = 26'($urandom % 32'h0300_0000);
         if ((it % 4) == 0) a[23:0] = 24'hFF_FFF0 | 24'($urandom % 16);
         if ((it % 11) == 0) a[25:24] = 2'd3;
         n = 1 + int'($urandom % 4);
         host_read(a, n);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule